// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the software-facing register bank of a simple display controller. A processor reaches it over a 32-bit bus whose byte address selects one of six word registers: control, three timing words, status and subpanel. The unit decodes the control word into the configuration lines the frame engine uses. It holds the panel width and height as minus-one values and returns fixed patterns of reserved ones on reads. Any address outside the six words, or not word aligned, is flagged as a bad access.

The frame engine sends single-cycle pulses when a frame completes, when the palette has been loaded and when it loses sync. Each pulse sets a sticky flag that the status register reports. A single level interrupt combines these flags: the frame and palette sources are individually masked, and a sync error always raises the line. When software changes the enable bit, the unit clears or sets flags as the edge requires and sends the frame engine a one-cycle pulse for the rising or falling edge.

Top module: `disp_reg_irq`

## Requirements
- R1: After a synchronous active-low reset every stored field and flag is zero. Control reads 0xFE000C34, timing0 reads 0x0000000F, timing2 reads 0xFC000000, and timing1, status and subpanel read 0. The interrupt and both edge pulses are low.
- R2: Word registers sit at byte offsets 0x00 control, 0x04 timing0, 0x08 timing1, 0x0C timing2, 0x10 status and 0x14 subpanel. An access to any other offset, or one with address bits 1:0 not zero, raises `bus_bad` combinationally. Such a read returns 0 and such a write changes nothing.
- R3: The control word holds enable in bit 0, mono in bit 1, the interrupt mask in bits 4:3, the TFT select in bit 7 and the palette-load mode in bits 21:20. The bits in mask 0x01CFF300 are stored as written. A read returns these fields in place, ORed with 0xFE000C34, with TFT copied into bit 23 as well.
- R4: Bits 9:0 of timing0 hold the width minus one and bits 9:0 of timing1 hold the height minus one; both appear on the configuration outputs. Bits 31:10 of both words are kept unchanged. A timing0 read forces bits 3:0 to one.
- R5: A timing2 read returns the stored word ORed with 0xFC000000. A subpanel write stores the value ANDed with 0xA1FFFFFF.
- R6: Status reads frame-done in bit 0, sync-error in bit 2 and palette-loaded in bit 6, with all other bits zero. A write to status changes no flag.
- R7: `irq` is high when frame-done is set with mask bit 0 set, when palette-loaded is set with mask bit 1 set, or whenever sync-error is set. Otherwise it is low.
- R8: A control write that takes enable from 1 to 0 clears sync-error. It also sets frame-done unless the palette-load mode written in that same write equals 1; in that case frame-done keeps its value.
- R9: A control write that takes enable from 0 to 1 clears frame-done and palette-loaded.
- R10: `en_rise` or `en_fall` is high for exactly the cycle after a control write that changes enable, in the direction of the change. A control write that leaves enable unchanged produces neither pulse.
- R11: An event pulse sets its flag on the next clock edge, and the flag then stays set until an enable edge clears it. When an event and an enable-edge write fall in the same cycle, a flag that the edge acts on takes the edge's value, and the other flags take the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| bus_bad | output | 1 | Access strobed at an unmapped or misaligned address |
| ev_frame_done | input | 1 | Frame-complete pulse from the frame engine |
| ev_palette_loaded | input | 1 | Palette-loaded pulse from the frame engine |
| ev_sync_error | input | 1 | Sync-lost pulse from the frame engine |
| irq | output | 1 | Level interrupt |
| en_rise | output | 1 | One-cycle pulse after enable is switched on |
| en_fall | output | 1 | One-cycle pulse after enable is switched off |
| cfg_enable | output | 1 | Decoded enable |
| cfg_mono | output | 1 | Decoded monochrome select |
| cfg_tft | output | 1 | Decoded TFT select |
| cfg_plm | output | 2 | Decoded palette-load mode |
| cfg_width_m1 | output | DIM_W | Panel width minus one |
| cfg_height_m1 | output | DIM_W | Panel height minus one |

## Verification
An enable-edge write to control and an event pulse from the frame engine can land on the same clock edge, and both then act on the same flags. The bench drives the write strobe and event pulses in the same cycle, on both a falling edge with palette-load mode 1 and a rising edge. It expects the flag the edge acts on to take the edge's value and every other flag to take the event. Each result is judged through the status read and the interrupt level, after a sweep over all mask values and flag combinations has fixed the interrupt equation.

// File: rtl/disp_reg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the display register unit.
// Assumes a 32-bit data bus; the reserved-one read patterns are fixed by
// the register layout and do not scale with parameters.
package disp_reg_pkg;
    localparam int DATA_W = 32;

    localparam logic [DATA_W-1:0] CTRL_RD_ONES  = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] CTRL_KEEP_MSK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] TIM0_RD_ONES  = 32'h0000_000F;
    localparam logic [DATA_W-1:0] TIM2_RD_ONES  = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUBP_WR_MSK   = 32'hA1FF_FFFF;

    localparam int NUM_REGS = 6;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_TIM0 = 3'd1,
        SEL_TIM1 = 3'd2,
        SEL_TIM2 = 3'd3,
        SEL_STAT = 3'd4,
        SEL_SUBP = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic pl;   // palette loaded
        logic se;   // sync error
        logic fd;   // frame done
    } flags_t;
endpackage

// File: rtl/disp_addr_dec.sv
`timescale 1ns/1ps
// disp_addr_dec: maps a byte address onto one of the register selects.
// Assumes word registers at consecutive word indices from zero; anything
// misaligned or past the last register selects SEL_NONE.
module disp_addr_dec
    import disp_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // Decode the word index into a register select.
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00 && idx < IDX_W'(NUM_REGS)) begin
            sel = reg_sel_e'(idx[2:0]);
        end
    end
endmodule

// File: rtl/disp_status_flags.sv
`timescale 1ns/1ps
// disp_status_flags: the three sticky status flags.
// Events set flags; an enable edge in the same cycle overrides only the
// flags it acts on. Assumes the edge strobes are single-cycle.
module disp_status_flags
    import disp_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_fd,
    input  logic       ev_pl,
    input  logic       ev_se,
    input  logic       rise_c,
    input  logic       fall_c,
    input  logic [1:0] plm_new,
    output flags_t     flags
);
    flags_t flags_q, flags_d;

    // Merge events, then apply the edge actions on top.
    always_comb begin
        flags_d.fd = flags_q.fd | ev_fd;
        flags_d.pl = flags_q.pl | ev_pl;
        flags_d.se = flags_q.se | ev_se;
        if (rise_c) begin
            flags_d.fd = 1'b0;
            flags_d.pl = 1'b0;
        end
        if (fall_c) begin
            flags_d.se = 1'b0;
            if (plm_new != 2'd1) flags_d.fd = 1'b1;
        end
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    p_rise_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c |=> (!flags.fd && !flags.pl));
    p_fall_fd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_c && plm_new != 2'd1) |=> (flags.fd && !flags.se));
endmodule

// File: rtl/disp_irq_gen.sv
`timescale 1ns/1ps
// disp_irq_gen: level interrupt from the status flags.
// Frame and palette sources are masked; sync error is never masked.
module disp_irq_gen
    import disp_reg_pkg::*;
(
    input  flags_t     flags,
    input  logic [1:0] mask,
    output logic       irq
);
    // Combine masked and unmasked sources.
    always_comb begin
        irq = flags.se | (flags.fd & mask[0]) | (flags.pl & mask[1]);
    end
endmodule

// File: rtl/disp_cfg_regs.sv
`timescale 1ns/1ps
// disp_cfg_regs: register storage, read mux and enable-edge detection.
// Assumes one access per cycle and a decoded select from disp_addr_dec.
module disp_cfg_regs
    import disp_reg_pkg::*;
#(
    parameter int DIM_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  flags_t            flags,
    output logic [DATA_W-1:0] rdata,
    output logic              en_o,
    output logic              mono_o,
    output logic              tft_o,
    output logic [1:0]        plm_o,
    output logic [1:0]        mask_o,
    output logic [DIM_W-1:0]  width_m1_o,
    output logic [DIM_W-1:0]  height_m1_o,
    output logic              rise_c,
    output logic              fall_c,
    output logic [1:0]        plm_wr,
    output logic              en_rise,
    output logic              en_fall
);
    localparam int OPQ_W = DATA_W - DIM_W;

    logic              en_q, mono_q, tft_q;
    logic [1:0]        plm_q, mask_q;
    logic [DATA_W-1:0] keep_q, tim2_q, subp_q;
    logic [OPQ_W-1:0]  t0_opq_q, t1_opq_q;
    logic [DIM_W-1:0]  wid_q, hgt_q;
    logic              rise_q, fall_q;
    logic              ctrl_wr;

    // Enable-edge strobes from a control write.
    always_comb begin
        ctrl_wr = wr && (sel == SEL_CTRL);
        rise_c  = ctrl_wr && !en_q && wdata[0];
        fall_c  = ctrl_wr && en_q && !wdata[0];
        plm_wr  = wdata[21:20];
    end

    // Register writes and the registered edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; mono_q <= 1'b0; tft_q <= 1'b0;
            plm_q <= '0; mask_q <= '0; keep_q <= '0;
            t0_opq_q <= '0; t1_opq_q <= '0; wid_q <= '0; hgt_q <= '0;
            tim2_q <= '0; subp_q <= '0;
            rise_q <= 1'b0; fall_q <= 1'b0;
        end else begin
            rise_q <= rise_c;
            fall_q <= fall_c;
            if (wr) begin
                case (sel)
                    SEL_CTRL: begin
                        en_q   <= wdata[0];
                        mono_q <= wdata[1];
                        mask_q <= wdata[4:3];
                        tft_q  <= wdata[7];
                        plm_q  <= wdata[21:20];
                        keep_q <= wdata & CTRL_KEEP_MSK;
                    end
                    SEL_TIM0: begin
                        t0_opq_q <= wdata[DATA_W-1:DIM_W];
                        wid_q    <= wdata[DIM_W-1:0];
                    end
                    SEL_TIM1: begin
                        t1_opq_q <= wdata[DATA_W-1:DIM_W];
                        hgt_q    <= wdata[DIM_W-1:0];
                    end
                    SEL_TIM2: tim2_q <= wdata;
                    SEL_SUBP: subp_q <= wdata & SUBP_WR_MSK;
                    default: ;
                endcase
            end
        end
    end

    // Read mux with reserved-one patterns.
    always_comb begin
        case (sel)
            SEL_CTRL: rdata = CTRL_RD_ONES | keep_q |
                              {8'd0, tft_q, 1'b0, plm_q, 12'd0, tft_q, 2'd0,
                               mask_q, 1'b0, mono_q, en_q};
            SEL_TIM0: rdata = {t0_opq_q, wid_q} | TIM0_RD_ONES;
            SEL_TIM1: rdata = {t1_opq_q, hgt_q};
            SEL_TIM2: rdata = tim2_q | TIM2_RD_ONES;
            SEL_STAT: rdata = {25'd0, flags.pl, 3'd0, flags.se, 1'b0, flags.fd};
            SEL_SUBP: rdata = subp_q;
            default:  rdata = '0;
        endcase
    end

    assign en_o = en_q;
    assign mono_o = mono_q;
    assign tft_o = tft_q;
    assign plm_o = plm_q;
    assign mask_o = mask_q;
    assign width_m1_o = wid_q;
    assign height_m1_o = hgt_q;
    assign en_rise = rise_q;
    assign en_fall = fall_q;

    p_edge_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |-> (en_o && !en_fall));
    p_fall_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |-> !en_o);
    p_no_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_CTRL && wdata[0] == en_o) |=> (!en_rise && !en_fall));
endmodule

// File: rtl/disp_reg_irq.sv
`timescale 1ns/1ps
// disp_reg_irq: top of the display register and interrupt unit.
// Assumes single-cycle event pulses from the frame engine and at most one
// bus access per cycle; reads are combinational from the address.
module disp_reg_irq
    import disp_reg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_bad,
    input  logic              ev_frame_done,
    input  logic              ev_palette_loaded,
    input  logic              ev_sync_error,
    output logic              irq,
    output logic              en_rise,
    output logic              en_fall,
    output logic              cfg_enable,
    output logic              cfg_mono,
    output logic              cfg_tft,
    output logic [1:0]        cfg_plm,
    output logic [DIM_W-1:0]  cfg_width_m1,
    output logic [DIM_W-1:0]  cfg_height_m1
);
    reg_sel_e   sel;
    flags_t     flags;
    logic [1:0] mask, plm_wr;
    logic       rise_c, fall_c;

    disp_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    disp_cfg_regs #(.DIM_W(DIM_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .wr          (bus_wr),
        .wdata       (bus_wdata),
        .flags       (flags),
        .rdata       (bus_rdata),
        .en_o        (cfg_enable),
        .mono_o      (cfg_mono),
        .tft_o       (cfg_tft),
        .plm_o       (cfg_plm),
        .mask_o      (mask),
        .width_m1_o  (cfg_width_m1),
        .height_m1_o (cfg_height_m1),
        .rise_c      (rise_c),
        .fall_c      (fall_c),
        .plm_wr      (plm_wr),
        .en_rise     (en_rise),
        .en_fall     (en_fall)
    );

    disp_status_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_fd   (ev_frame_done),
        .ev_pl   (ev_palette_loaded),
        .ev_se   (ev_sync_error),
        .rise_c  (rise_c),
        .fall_c  (fall_c),
        .plm_new (plm_wr),
        .flags   (flags)
    );

    disp_irq_gen u_irq (
        .flags (flags),
        .mask  (mask),
        .irq   (irq)
    );

    // Bad-access flag for strobed accesses outside the map.
    always_comb begin
        bus_bad = (bus_rd || bus_wr) && (sel == SEL_NONE);
    end

    p_sync_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags.se |-> irq);
    p_bad_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_bad) |-> (bus_rdata == 32'd0));
    p_rise_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |-> (!flags.fd && !flags.pl));
    p_fall_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |-> !flags.se);
    p_fd_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags.fd |=> (flags.fd || en_rise));
    p_pl_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags.pl |=> (flags.pl || en_rise));
    p_se_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags.se |=> (flags.se || en_fall));
endmodule

// File: tb/disp_reg_irq_test.sv
`timescale 1ns/1ps
// Self-checking bench for disp_reg_irq.
module disp_reg_irq_test;
    localparam int ADDR_W = 8;
    localparam int DIM_W  = 10;

    localparam logic [7:0] A_CTRL = 8'h00, A_T0 = 8'h04, A_T1 = 8'h08,
                           A_T2 = 8'h0C, A_ST = 8'h10, A_SP = 8'h14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_bad;
    logic              ev_fd = 1'b0, ev_pl = 1'b0, ev_se = 1'b0;
    logic              irq, en_rise, en_fall;
    logic              cfg_enable, cfg_mono, cfg_tft;
    logic [1:0]        cfg_plm;
    logic [DIM_W-1:0]  cfg_width_m1, cfg_height_m1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    disp_reg_irq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_bad(bus_bad), .ev_frame_done(ev_fd),
        .ev_palette_loaded(ev_pl), .ev_sync_error(ev_se), .irq(irq),
        .en_rise(en_rise), .en_fall(en_fall), .cfg_enable(cfg_enable),
        .cfg_mono(cfg_mono), .cfg_tft(cfg_tft), .cfg_plm(cfg_plm),
        .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wr_ev(input logic [7:0] a, input logic [31:0] d,
                         input logic [2:0] ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        {ev_pl, ev_se, ev_fd} = ev;
        @(negedge clk);
        bus_wr = 1'b0; {ev_pl, ev_se, ev_fd} = 3'b000;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_ev(a, d, 3'b000);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d,
                      output logic bad);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata; bad = bus_bad;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk);
        {ev_pl, ev_se, ev_fd} = ev;
        @(negedge clk);
        {ev_pl, ev_se, ev_fd} = 3'b000;
    endtask

    function automatic logic [31:0] ctrl_exp(input logic [31:0] v);
        return 32'hFE000C34 | (v & 32'h01CFF300) | (32'(v[7]) << 23) |
               (32'(v[21:20]) << 20) | (32'(v[7]) << 7) |
               (32'(v[4:3]) << 3) | (32'(v[1]) << 1) | 32'(v[0]);
    endfunction

    function automatic logic [31:0] st_exp(input bit fd, input bit se, input bit pl);
        return (32'(pl) << 6) | (32'(se) << 2) | 32'(fd);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        logic bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, d, bad); chk(d == 32'hFE000C34, "R1 ctrl", d, 32'hFE000C34);
        rd(A_T0, d, bad);   chk(d == 32'h0000000F, "R1 t0", d, 32'hF);
        rd(A_T1, d, bad);   chk(d == 0, "R1 t1", d, 0);
        rd(A_T2, d, bad);   chk(d == 32'hFC000000, "R1 t2", d, 32'hFC000000);
        rd(A_ST, d, bad);   chk(d == 0, "R1 status", d, 0);
        rd(A_SP, d, bad);   chk(d == 0, "R1 subpanel", d, 0);
        chk(!irq && !en_rise && !en_fall && !cfg_enable, "R1 outputs",
            {irq, en_rise, en_fall, cfg_enable}, 0);

        // R2: bad offsets and misaligned accesses
        for (int a = 8'h18; a <= 8'hFC; a += 4) begin
            rd(8'(a), d, bad);
            chk(bad && d == 0, "R2 bad read", {bad, d[30:0]}, 32'h80000000);
        end
        rd(8'h01, d, bad); chk(bad && d == 0, "R2 misaligned", {31'd0, bad}, 1);
        rd(8'h16, d, bad); chk(bad && d == 0, "R2 misaligned", {31'd0, bad}, 1);
        rd(A_ST, d, bad);  chk(!bad, "R2 good offset", {31'd0, bad}, 0);
        wr(8'h18, 32'hFFFFFFFF);
        wr(8'h0D, 32'hFFFFFFFF);
        rd(A_T2, d, bad);  chk(d == 32'hFC000000, "R2 bad write t2", d, 32'hFC000000);
        rd(A_SP, d, bad);  chk(d == 0, "R2 bad write subpanel", d, 0);
        rd(A_CTRL, d, bad); chk(d == 32'hFE000C34, "R2 bad write ctrl", d, 32'hFE000C34);

        // R3: walking one through control
        for (int b = 0; b < 32; b++) begin
            wr(A_CTRL, 32'd1 << b);
            rd(A_CTRL, d, bad);
            e = ctrl_exp(32'd1 << b);
            chk(d == e, "R3 ctrl bit", d, e);
        end
        wr(A_CTRL, 32'h00300082);
        chk(cfg_tft && cfg_mono && cfg_plm == 2'd3 && !cfg_enable, "R3 decode",
            {cfg_tft, cfg_mono, cfg_plm, cfg_enable}, 5'b11110);
        rd(A_CTRL, d, bad); e = ctrl_exp(32'h00300082);
        chk(d == e, "R3 ctrl pattern", d, e);

        // R4 / R5: timing and subpanel sweeps
        for (int i = 0; i < 6; i++) begin
            logic [9:0]  w;
            logic [21:0] hi;
            w  = (i == 0) ? 10'd0 : (i == 1) ? 10'd1 : (i == 2) ? 10'h3FF :
                 (i == 3) ? 10'h155 : (i == 4) ? 10'h2AA : 10'h270;
            hi = 22'h3FFFFF ^ (22'(i) * 22'h12345);
            wr(A_T0, {hi, w});
            rd(A_T0, d, bad); e = {hi, w} | 32'hF;
            chk(d == e && cfg_width_m1 == w, "R4 timing0", d, e);
            wr(A_T1, {hi, ~w});
            rd(A_T1, d, bad); e = {hi, ~w};
            chk(d == e && cfg_height_m1 == ~w, "R4 timing1", d, e);
            e = {hi, w} ^ 32'h5A5A5A5A;
            wr(A_T2, e);
            rd(A_T2, d, bad);
            chk(d == (e | 32'hFC000000), "R5 timing2", d, e | 32'hFC000000);
            wr(A_SP, ~e);
            rd(A_SP, d, bad);
            chk(d == (~e & 32'hA1FFFFFF), "R5 subpanel", d, ~e & 32'hA1FFFFFF);
        end

        // R7 / R6: sweep every mask with every flag combination
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 8; f++) begin
                bit efd, ese, epl, eirq;
                efd = f[0]; ese = f[1]; epl = f[2];
                wr(A_CTRL, 32'h00100000);            // disable, mode 1
                wr(A_CTRL, 32'h00100001);            // enable, clears flags
                pulse({epl, ese, efd});
                wr(A_CTRL, 32'h00100001 | (32'(m) << 3));
                eirq = ese | (efd & m[0]) | (epl & m[1]);
                chk(irq == eirq, "R7 irq", {31'd0, irq}, {31'd0, eirq});
                wr(A_ST, 32'hFFFFFFFF);
                rd(A_ST, d, bad); e = st_exp(efd, ese, epl);
                chk(d == e, "R6 status after write", d, e);
            end
        end

        // R8: falling edge for every palette-load mode
        for (int p = 0; p < 4; p++) begin
            wr(A_CTRL, 32'h00100000);
            wr(A_CTRL, 32'h00000001 | (32'(p) << 20));
            pulse(3'b010);
            wr(A_CTRL, 32'(p) << 20);
            chk(en_fall && !en_rise, "R10 fall pulse", {en_rise, en_fall}, 2'b01);
            rd(A_ST, d, bad); e = st_exp(p != 1, 1'b0, 1'b0);
            chk(d == e, "R8 fall flags", d, e);
        end

        // R9 / R10: rising edge
        pulse(3'b101);
        wr(A_CTRL, 32'h00000001);
        chk(en_rise && !en_fall, "R10 rise pulse", {en_rise, en_fall}, 2'b10);
        rd(A_ST, d, bad); chk(d == 0, "R9 rise clears", d, 0);

        // R11: same-cycle event and falling edge, mode 1
        pulse(3'b010);
        wr_ev(A_CTRL, 32'h00100000, 3'b111);
        rd(A_ST, d, bad); e = st_exp(1'b1, 1'b0, 1'b1);
        chk(d == e, "R11 fall with events", d, e);

        // R11: same-cycle event and rising edge
        wr_ev(A_CTRL, 32'h00100001, 3'b111);
        rd(A_ST, d, bad); e = st_exp(1'b0, 1'b1, 1'b0);
        chk(d == e, "R11 rise with events", d, e);
        chk(irq, "R11 irq from sync", {31'd0, irq}, 1);

        // R10: no pulse when enable is unchanged
        wr(A_CTRL, 32'h00100019);
        chk(!en_rise && !en_fall, "R10 no edge", {en_rise, en_fall}, 0);
        rd(A_ST, d, bad); chk(d == e, "R10 status kept", d, e);

        // R11: sticky after event ends
        pulse(3'b001);
        repeat (3) @(negedge clk);
        rd(A_ST, d, bad); e = st_exp(1'b1, 1'b1, 1'b0);
        chk(d == e, "R11 sticky", d, e);

        done = 1;
        summary();
        $finish;
    end
endmodule